// File: doc/BRIEF.md
# Centralized Scoreboard for Non-Pipelined Functional Units

This block controls the hazards of a small machine in which several non-pipelined functional units run out of order. Instructions come in program order, each naming a target unit, an opcode, a destination and two source registers. The block holds one status entry for each unit. Each instruction has that unit's number as its only identity. A second table records, for every register, which unit will write it next. Each instruction goes through four phases: issue, operand read, execution and write-back. The stall output tells the front end to hold the current instruction.

Read-after-write hazards are handled in the operand-read phase. A unit gets a read grant only when both of its sources are free of pending producers. Write-after-write and structural hazards stop the instruction at issue. Write-after-read hazards do not stop issue. A unit that has finished executing can only write back once every earlier reader of its destination has read the old value. The execution units report completion on `exec_done`. A write-back wakes every waiting consumer of that unit and frees the unit's entry and its register claim. The block has no commit phase, so the order of results is not precise.

Top module: `sb_scoreboard`

## Requirements
- R1: After reset every unit is idle: `rd_grant` and `wb_en` are all zero, and an instruction offered to any unit is accepted (`iss_stall` low).
- R2: An instruction offered to a unit that is busy and not writing back in that cycle is stalled. It stays stalled until that unit's write-back cycle.
- R3: An instruction whose destination is already claimed by a unit that is not writing back in that cycle is stalled (write-after-write).
- R4: A write-back is taken before an issue in the same cycle. An instruction targeting the unit that is writing back, or whose destination is claimed only by that unit, is accepted in that same cycle.
- R5: A unit whose source is claimed by another unit gets no `rd_grant` until that producer writes back. It is granted in the cycle after the producer's `wb_en` at the earliest.
- R6: A source with no pending producer at issue counts as ready at once. This includes a producer that writes back in the issue cycle. An instruction whose sources are both ready is granted in the cycle after issue.
- R7: A unit that has finished executing asserts `wb_en` only when no other busy unit still waits to read the old value of its destination (write-after-read).
- R8: `exec_done` on an executing unit makes it eligible for write-back in the next cycle. While `wb_en[u]` is high, bits `u*REG_W +: REG_W` of `fu_dst` carry that unit's destination register.
- R9: `rd_grant` lasts one cycle per instruction. Once a reader has been granted it no longer holds back any writer of its source registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| iss_valid | input | 1 | Front end offers an instruction |
| iss_fu | input | FU_W | Functional unit the instruction targets |
| iss_op | input | OP_W | Opcode, held for the unit |
| iss_dst | input | REG_W | Destination register |
| iss_src1 | input | REG_W | First source register |
| iss_src2 | input | REG_W | Second source register |
| iss_stall | output | 1 | Instruction not accepted this cycle; hold it |
| exec_done | input | NUM_FU | Per-unit pulse: execution finished |
| rd_grant | output | NUM_FU | Per-unit strobe: read the operands now |
| wb_en | output | NUM_FU | Per-unit strobe: write the result now |
| fu_op | output | NUM_FU*OP_W | Opcode held by each unit |
| fu_dst | output | NUM_FU*REG_W | Destination held by each unit |

## Verification
The assertions assume that the execution side raises `exec_done` only for a unit that is executing, after it has been granted and before it writes back. They also assume that the front end keeps an offered instruction unchanged while it is stalled. The bench models each unit as a latency counter. The counter is loaded in the edge after `rd_grant` and raises `exec_done` exactly once when it expires, so completion never arrives in another phase. The front end is a queue that pops only when the model expects acceptance, so a stalled instruction stays on the inputs.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_EXEC = 2'd2,
        ST_DONE = 2'd3
    } sb_stage_e;
endpackage

// File: rtl/sb_issue_gate.sv
module sb_issue_gate #(
    parameter int NUM_FU  = 4,
    parameter int NUM_REG = 8,
    localparam int FU_W   = (NUM_FU > 1) ? $clog2(NUM_FU) : 1,
    localparam int REG_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
    input  logic                             iss_valid,
    input  logic [FU_W-1:0]                  iss_fu,
    input  logic [REG_W-1:0]                 iss_dst,
    input  logic [NUM_FU-1:0]                busy,
    input  logic [NUM_FU-1:0]                wb_en,
    input  logic [NUM_REG-1:0]               res_vld,
    input  logic [NUM_REG-1:0][FU_W-1:0]     res_fu,
    output logic                             iss_stall,
    output logic                             iss_fire
);
    logic unit_blocked;
    logic dst_blocked;

    always_comb begin
        // a unit releasing this cycle can take the new instruction
        unit_blocked = busy[iss_fu] && !wb_en[iss_fu];
        dst_blocked  = res_vld[iss_dst] && !wb_en[res_fu[iss_dst]];
        iss_stall    = iss_valid && (unit_blocked || dst_blocked);
        iss_fire     = iss_valid && !unit_blocked && !dst_blocked;
    end
endmodule

// File: rtl/sb_war_gate.sv
module sb_war_gate #(
    parameter int NUM_FU  = 4,
    parameter int NUM_REG = 8,
    localparam int REG_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
    input  sb_pkg::sb_stage_e [NUM_FU-1:0]   stage,
    input  logic [NUM_FU-1:0][REG_W-1:0]     fi,
    input  logic [NUM_FU-1:0][REG_W-1:0]     fj,
    input  logic [NUM_FU-1:0][REG_W-1:0]     fk,
    input  logic [NUM_FU-1:0]                rj,
    input  logic [NUM_FU-1:0]                rk,
    output logic [NUM_FU-1:0]                wb_en
);
    import sb_pkg::*;

    always_comb begin
        for (int u = 0; u < NUM_FU; u++) begin
            wb_en[u] = (stage[u] == ST_DONE);
            for (int v = 0; v < NUM_FU; v++) begin
                // an unread, ready source equal to our destination blocks us
                if (v != u && stage[v] == ST_WAIT &&
                    ((rj[v] && fj[v] == fi[u]) || (rk[v] && fk[v] == fi[u])))
                    wb_en[u] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard #(
    parameter int NUM_FU  = 4,
    parameter int NUM_REG = 8,
    parameter int OP_W    = 4,
    localparam int FU_W   = (NUM_FU > 1) ? $clog2(NUM_FU) : 1,
    localparam int REG_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        iss_valid,
    input  logic [FU_W-1:0]             iss_fu,
    input  logic [OP_W-1:0]             iss_op,
    input  logic [REG_W-1:0]            iss_dst,
    input  logic [REG_W-1:0]            iss_src1,
    input  logic [REG_W-1:0]            iss_src2,
    output logic                        iss_stall,
    input  logic [NUM_FU-1:0]           exec_done,
    output logic [NUM_FU-1:0]           rd_grant,
    output logic [NUM_FU-1:0]           wb_en,
    output logic [NUM_FU*OP_W-1:0]      fu_op,
    output logic [NUM_FU*REG_W-1:0]     fu_dst
);
    import sb_pkg::*;

    typedef struct packed {
        sb_stage_e [NUM_FU-1:0]            stage;
        logic [NUM_FU-1:0][OP_W-1:0]       op;
        logic [NUM_FU-1:0][REG_W-1:0]      fi;
        logic [NUM_FU-1:0][REG_W-1:0]      fj;
        logic [NUM_FU-1:0][REG_W-1:0]      fk;
        logic [NUM_FU-1:0][FU_W-1:0]       qj;
        logic [NUM_FU-1:0][FU_W-1:0]       qk;
        logic [NUM_FU-1:0]                 pj;
        logic [NUM_FU-1:0]                 pk;
        logic [NUM_FU-1:0]                 rj;
        logic [NUM_FU-1:0]                 rk;
        logic [NUM_REG-1:0]                res_vld;
        logic [NUM_REG-1:0][FU_W-1:0]      res_fu;
    } sb_state_t;

    sb_state_t s_d, s_q;
    logic [NUM_FU-1:0] busy;
    logic              iss_fire;

    always_comb begin
        for (int u = 0; u < NUM_FU; u++) begin
            busy[u]     = (s_q.stage[u] != ST_IDLE);
            rd_grant[u] = (s_q.stage[u] == ST_WAIT) && s_q.rj[u] && s_q.rk[u];
            fu_op[u*OP_W +: OP_W]    = s_q.op[u];
            fu_dst[u*REG_W +: REG_W] = s_q.fi[u];
        end
    end

    sb_issue_gate #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) u_issue (
        .iss_valid (iss_valid),
        .iss_fu    (iss_fu),
        .iss_dst   (iss_dst),
        .busy      (busy),
        .wb_en     (wb_en),
        .res_vld   (s_q.res_vld),
        .res_fu    (s_q.res_fu),
        .iss_stall (iss_stall),
        .iss_fire  (iss_fire)
    );

    sb_war_gate #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) u_war (
        .stage (s_q.stage),
        .fi    (s_q.fi),
        .fj    (s_q.fj),
        .fk    (s_q.fk),
        .rj    (s_q.rj),
        .rk    (s_q.rk),
        .wb_en (wb_en)
    );

    always_comb begin
        s_d = s_q;
        // write-back: release unit, wake consumers, drop register claim
        for (int u = 0; u < NUM_FU; u++) begin
            if (wb_en[u]) begin
                s_d.stage[u] = ST_IDLE;
                s_d.rj[u]    = 1'b0;
                s_d.rk[u]    = 1'b0;
                for (int v = 0; v < NUM_FU; v++) begin
                    if (s_q.pj[v] && s_q.qj[v] == FU_W'(u)) begin
                        s_d.pj[v] = 1'b0;
                        s_d.rj[v] = 1'b1;
                    end
                    if (s_q.pk[v] && s_q.qk[v] == FU_W'(u)) begin
                        s_d.pk[v] = 1'b0;
                        s_d.rk[v] = 1'b1;
                    end
                end
                if (s_q.res_vld[s_q.fi[u]] && s_q.res_fu[s_q.fi[u]] == FU_W'(u))
                    s_d.res_vld[s_q.fi[u]] = 1'b0;
            end
        end
        // operand read and execution completion
        for (int u = 0; u < NUM_FU; u++) begin
            if (rd_grant[u]) begin
                s_d.stage[u] = ST_EXEC;
                s_d.rj[u]    = 1'b0;
                s_d.rk[u]    = 1'b0;
            end else if (s_q.stage[u] == ST_EXEC && exec_done[u]) begin
                s_d.stage[u] = ST_DONE;
            end
        end
        // issue last, so a same-cycle release is already applied
        if (iss_fire) begin
            s_d.stage[iss_fu] = ST_WAIT;
            s_d.op[iss_fu]    = iss_op;
            s_d.fi[iss_fu]    = iss_dst;
            s_d.fj[iss_fu]    = iss_src1;
            s_d.fk[iss_fu]    = iss_src2;
            s_d.qj[iss_fu]    = s_q.res_fu[iss_src1];
            s_d.qk[iss_fu]    = s_q.res_fu[iss_src2];
            s_d.pj[iss_fu]    = s_q.res_vld[iss_src1] && !wb_en[s_q.res_fu[iss_src1]];
            s_d.pk[iss_fu]    = s_q.res_vld[iss_src2] && !wb_en[s_q.res_fu[iss_src2]];
            s_d.rj[iss_fu]    = !s_d.pj[iss_fu];
            s_d.rk[iss_fu]    = !s_d.pk[iss_fu];
            s_d.res_vld[iss_dst] = 1'b1;
            s_d.res_fu[iss_dst]  = iss_fu;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3: an accepted instruction owns its destination in the next cycle
    a_r3_dst_claimed: assert property (@(posedge clk) disable iff (!rst_n)
        iss_fire |=> (s_q.res_vld[$past(iss_dst)] && s_q.res_fu[$past(iss_dst)] == $past(iss_fu)));

    // R6: sources without a producer lead to a grant right after issue
    a_r6_free_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_fire && !s_q.res_vld[iss_src1] && !s_q.res_vld[iss_src2]) |=> rd_grant[$past(iss_fu)]);

    for (genvar g = 0; g < NUM_FU; g++) begin : g_chk
        // R9: operand read is a single-cycle strobe
        a_r9_grant_single: assert property (@(posedge clk) disable iff (!rst_n)
            rd_grant[g] |=> !rd_grant[g]);
        // R8: completion only reported for an executing unit
        a_r8_done_legal: assert property (@(posedge clk) disable iff (!rst_n)
            exec_done[g] |-> (s_q.stage[g] == ST_EXEC));
        // R4: a write-back without a same-cycle reissue leaves the unit idle
        a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
            (wb_en[g] && !(iss_fire && iss_fu == FU_W'(g))) |=> (s_q.stage[g] == ST_IDLE));
    end
endmodule

// File: tb/sb_scoreboard_tb.sv
module sb_scoreboard_tb;
    localparam int NF = 4;
    localparam int NR = 8;

    logic clk = 0;
    logic rst_n = 0;
    logic iss_valid = 0;
    logic [1:0] iss_fu = 0;
    logic [3:0] iss_op = 0;
    logic [2:0] iss_dst = 0, iss_src1 = 0, iss_src2 = 0;
    logic iss_stall;
    logic [NF-1:0] exec_done = 0;
    logic [NF-1:0] rd_grant, wb_en;
    logic [NF*4-1:0] fu_op;
    logic [NF*3-1:0] fu_dst;

    always #4 clk = ~clk;

    sb_scoreboard u_dut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_fu(iss_fu),
        .iss_op(iss_op), .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
        .iss_stall(iss_stall), .exec_done(exec_done), .rd_grant(rd_grant),
        .wb_en(wb_en), .fu_op(fu_op), .fu_dst(fu_dst)
    );

    typedef struct { int fu; int dst; int s1; int s2; } ins_t;
    ins_t q[$];

    int checks = 0, errors = 0, cycles = 0;
    string phase = "R1";
    int lat[NF] = '{2, 4, 3, 6};
    int m_stage[NF], m_dst[NF], m_s1[NF], m_s2[NF], m_p1[NF], m_p2[NF], ex_cnt[NF];
    int m_prod[NR];

    task automatic chk(bit ok, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", phase, what, act, exp);
        end
    endtask

    function automatic bit any_busy();
        for (int u = 0; u < NF; u++) if (m_stage[u] != 0) return 1;
        return 0;
    endfunction

    task automatic step();
        bit e_wb[NF], e_gr[NF], e_stall, fired;
        ins_t h;
        @(negedge clk);
        iss_valid = (q.size() > 0);
        if (q.size() > 0) begin
            h = q[0];
            iss_fu = 2'(h.fu); iss_dst = 3'(h.dst); iss_src1 = 3'(h.s1); iss_src2 = 3'(h.s2);
            iss_op = 4'(h.fu + h.dst);
        end
        for (int u = 0; u < NF; u++) exec_done[u] = (ex_cnt[u] == 1);
        #1;
        // expected write-back: done and no unread earlier reader of dst
        for (int u = 0; u < NF; u++) begin
            e_wb[u] = (m_stage[u] == 3);
            for (int v = 0; v < NF; v++)
                if (v != u && m_stage[v] == 1 &&
                    ((m_s1[v] == m_dst[u] && m_p1[v] < 0) || (m_s2[v] == m_dst[u] && m_p2[v] < 0)))
                    e_wb[u] = 0;
            e_gr[u] = (m_stage[u] == 1 && m_p1[u] < 0 && m_p2[u] < 0);
        end
        e_stall = 0;
        if (iss_valid) begin
            if (m_stage[h.fu] != 0 && !e_wb[h.fu]) e_stall = 1;
            if (m_prod[h.dst] >= 0 && !e_wb[m_prod[h.dst]]) e_stall = 1;
            chk(iss_stall == e_stall, "iss_stall", int'(iss_stall), int'(e_stall));
        end
        for (int u = 0; u < NF; u++) begin
            chk(rd_grant[u] == e_gr[u], $sformatf("rd_grant[%0d]", u), int'(rd_grant[u]), int'(e_gr[u]));
            chk(wb_en[u] == e_wb[u], $sformatf("wb_en[%0d]", u), int'(wb_en[u]), int'(e_wb[u]));
            if (e_wb[u])
                chk(int'(fu_dst[u*3 +: 3]) == m_dst[u], $sformatf("R8 fu_dst[%0d]", u),
                    int'(fu_dst[u*3 +: 3]), m_dst[u]);
        end
        fired = iss_valid && !e_stall;
        // model update for the coming edge
        for (int w = 0; w < NF; w++) if (e_wb[w]) begin
            m_stage[w] = 0;
            for (int v = 0; v < NF; v++) begin
                if (m_p1[v] == w) m_p1[v] = -1;
                if (m_p2[v] == w) m_p2[v] = -1;
            end
            if (m_prod[m_dst[w]] == w) m_prod[m_dst[w]] = -1;
        end
        for (int u = 0; u < NF; u++) begin
            if (m_stage[u] == 2 && exec_done[u]) m_stage[u] = 3;
            if (e_gr[u]) m_stage[u] = 2;
            if (exec_done[u]) ex_cnt[u] = -1;
            else if (ex_cnt[u] > 1) ex_cnt[u]--;
            if (e_gr[u]) ex_cnt[u] = lat[u];
        end
        if (fired) begin
            m_stage[h.fu] = 1;
            m_dst[h.fu] = h.dst; m_s1[h.fu] = h.s1; m_s2[h.fu] = h.s2;
            m_p1[h.fu] = m_prod[h.s1];
            m_p2[h.fu] = m_prod[h.s2];
            m_prod[h.dst] = h.fu;
            void'(q.pop_front());
        end
    endtask

    task automatic push(int fu, int dst, int s1, int s2);
        ins_t i;
        i.fu = fu; i.dst = dst; i.s1 = s1; i.s2 = s2;
        q.push_back(i);
    endtask

    task automatic run_phase(string tag);
        int n = 0;
        phase = tag;
        while ((q.size() > 0 || any_busy()) && n < 5000) begin
            step();
            n++;
        end
        chk(n < 5000, "phase drained", n, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lf;
        for (int u = 0; u < NF; u++) begin
            m_stage[u] = 0; m_p1[u] = -1; m_p2[u] = -1; ex_cnt[u] = -1;
            m_dst[u] = 0; m_s1[u] = 0; m_s2[u] = 0;
        end
        for (int r = 0; r < NR; r++) m_prod[r] = -1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: idle after reset
        @(negedge clk);
        #1;
        chk(rd_grant == 0, "R1 rd_grant", int'(rd_grant), 0);
        chk(wb_en == 0, "R1 wb_en", int'(wb_en), 0);
        chk(iss_stall == 0, "R1 iss_stall", int'(iss_stall), 0);
        iss_valid = 1; iss_fu = 3; iss_dst = 7;
        #1;
        chk(iss_stall == 0, "R1 accept after reset", int'(iss_stall), 0);
        iss_valid = 0;

        push(0, 1, 2, 3);                       run_phase("R6");
        push(1, 4, 1, 2); push(1, 5, 1, 2);     run_phase("R2");
        push(3, 2, 0, 0); push(0, 2, 1, 1);     run_phase("R3");
        push(2, 6, 0, 0); push(2, 7, 6, 0);
        push(0, 3, 0, 0); push(1, 3, 3, 0);     run_phase("R4");
        push(1, 1, 2, 3); push(0, 4, 1, 1);
        push(2, 5, 4, 1);                       run_phase("R5");
        push(1, 2, 0, 0); push(3, 6, 1, 2);
        push(0, 1, 3, 3);                       run_phase("R7");
        push(2, 4, 1, 1); push(3, 1, 5, 5);     run_phase("R9");
        lf = 32'h1ACE5;
        for (int i = 0; i < 60; i++) begin
            lf = (lf << 1) ^ (((lf >> 16) ^ (lf >> 13)) & 1);
            lf = lf & 32'h1FFFF;
            push(lf % 4, (lf >> 2) % 8, (lf >> 5) % 8, (lf >> 8) % 8);
        end
        run_phase("R8");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule